// File: doc/BRIEF.md
# IN Endpoint Control and Status Register

This block is the 8-bit control and status register of a non-control IN endpoint in a USB device controller. The CPU reads and writes it over a simple register bus. Hardware inputs from the FIFO and the serial engine report four events: a packet was transmitted, a FIFO fill completed, the FIFO holds a packet, and the FIFO underran. The block tracks whether a packet is armed for transmission. It drives a stall request, a one-cycle FIFO flush, a one-cycle data-toggle reset, the isochronous and interrupt transfer-type modes, and a one-cycle underrun interrupt pulse.

The packet-ready handshake is a two-state machine, `PK_IDLE` and `PK_ARMED`. The transitions are:

- `PK_IDLE` to `PK_ARMED` (the arm transition): the CPU writes 1 to bit 0, or auto-arm fires. Auto-arm fires when the auto bit is set, the FIFO is in single-buffer mode and a fill completes.
- `PK_ARMED` to `PK_IDLE` (the sent transition): a transmission completes.
- `PK_ARMED` to `PK_IDLE` (the flush transition): the CPU writes 1 to the flush bit.

A flush written in the same cycle as an arm request keeps the machine in `PK_IDLE`.

Bit layout, fixed because software decodes it: b0 packet-ready, b1 underrun, b2 stall, b3 isochronous/toggle-reset, b4 interrupt mode, b5 FIFO-not-empty, b6 flush, b7 auto-arm.

Top module: `inep_csr`

## Requirements
- R1: After reset `csr_rdata` is 0x00 with `fifo_full` low. `pkt_rdy`, `stall`, `flush`, `tog_rst`, `iso_mode`, `intr_mode` and `ur_irq` are all 0.
- R2: A write with bit 0 set makes bit 0 of `csr_rdata` and `pkt_rdy` read 1 from the next cycle. A write with bit 0 clear leaves a pending packet-ready bit at 1.
- R3: A `tx_done` pulse while armed clears packet-ready on the next cycle.
- R4: A `fill_done` pulse arms packet-ready only when bit 7 (auto) reads 1 and `single_buf` is 1. Otherwise the pulse has no effect.
- R5: A write with bit 6 set produces `flush` high for exactly one cycle and clears packet-ready, even if bit 0 is set in the same write. Bit 6 always reads 0.
- R6: Each write with bit 3 set produces `tog_rst` high for exactly one cycle. Bit 3 is stored and drives `iso_mode`.
- R7: An `underrun` pulse while `iso_mode` is 1 sets bit 1 and produces `ur_irq` high for one cycle. With `iso_mode` at 0 the pulse is ignored.
- R8: A write with bit 1 clear clears the underrun bit. A write with bit 1 set leaves it unchanged. An underrun in the same cycle as a clearing write leaves it at 1.
- R9: Bit 5 reads the `fifo_full` input directly, and writes to bit 5 have no effect.
- R10: Bits 2 and 4 are read/write and drive `stall` and `intr_mode`.
- R11: When armed, a `tx_done` pulse coinciding with an auto-arm `fill_done` leaves packet-ready at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data |
| tx_done | input | 1 | Packet transmission completed (pulse) |
| fill_done | input | 1 | CPU or DMA finished filling a packet (pulse) |
| fifo_full | input | 1 | FIFO holds a packet |
| underrun | input | 1 | FIFO underrun event (pulse) |
| single_buf | input | 1 | FIFO configured for single buffering |
| pkt_rdy | output | 1 | Packet armed for transmission |
| stall | output | 1 | Stall handshake request |
| flush | output | 1 | One-cycle FIFO flush command |
| tog_rst | output | 1 | One-cycle data-toggle reset |
| iso_mode | output | 1 | Isochronous transfer mode |
| intr_mode | output | 1 | Interrupt transfer mode with rate feedback |
| ur_irq | output | 1 | One-cycle underrun interrupt pulse |

## Verification
Packet-ready is driven four ways: by a CPU set, by CPU writes with bit 0 clear, by auto-arm with each enable missing in turn, and by a flush combined with a set. These patterns separate a write-0 that wrongly clears from a correct one, and an auto-arm gated by the wrong condition from the correct gate. Underrun is raised both inside and outside isochronous mode and against clearing and non-clearing writes in the same cycle, which shows whether hardware wins the collision. Repeated toggle-reset writes confirm that the pulse fires on every write rather than once per level change.

// File: rtl/inep_csr_pkg.sv
package inep_csr_pkg;
    localparam int CSR_W     = 8;
    localparam int B_PRDY    = 0;
    localparam int B_URUN    = 1;
    localparam int B_STALL   = 2;
    localparam int B_ISO     = 3;
    localparam int B_INTR    = 4;
    localparam int B_NEMPTY  = 5;
    localparam int B_FLUSH   = 6;
    localparam int B_AUTO    = 7;

    typedef enum logic {
        PK_IDLE  = 1'b0,
        PK_ARMED = 1'b1
    } pk_state_e;
endpackage

// File: rtl/inep_pkt_fsm.sv
module inep_pkt_fsm
    import inep_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_cpu,
    input  logic set_auto,
    input  logic clr_tx,
    input  logic clr_flush,
    output logic pkt_rdy
);
    pk_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PK_IDLE:  if (!clr_flush && (set_cpu || set_auto)) state_d = PK_ARMED;
            PK_ARMED: if (clr_flush || clr_tx)                 state_d = PK_IDLE;
            default:  state_d = PK_IDLE;
        endcase
    end

    assign pkt_rdy = (state_q == PK_ARMED);

    // R3 / R11: completion while armed always returns to idle
    a_r3_tx_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_rdy && clr_tx) |=> !pkt_rdy);
    // R5: flush always leaves the machine idle
    a_r5_flush_idles: assert property (@(posedge clk) disable iff (!rst_n)
        clr_flush |=> !pkt_rdy);
    // R2: a CPU set without flush always arms
    a_r2_cpu_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cpu && !clr_flush && !pkt_rdy) |=> pkt_rdy);
endmodule

// File: rtl/inep_cfg_regs.sv
module inep_cfg_regs
    import inep_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             hw_underrun,
    output logic             urun_q,
    output logic             stall_q,
    output logic             iso_q,
    output logic             intr_q,
    output logic             auto_q,
    output logic             flush_p,
    output logic             tog_p,
    output logic             irq_p
);
    logic ur_hit;
    assign ur_hit = hw_underrun && iso_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
            iso_q   <= 1'b0;
            intr_q  <= 1'b0;
            auto_q  <= 1'b0;
            urun_q  <= 1'b0;
            flush_p <= 1'b0;
            tog_p   <= 1'b0;
            irq_p   <= 1'b0;
        end else begin
            flush_p <= wr_en && wr_data[B_FLUSH];
            tog_p   <= wr_en && wr_data[B_ISO];
            irq_p   <= ur_hit;
            if (wr_en) begin
                stall_q <= wr_data[B_STALL];
                iso_q   <= wr_data[B_ISO];
                intr_q  <= wr_data[B_INTR];
                auto_q  <= wr_data[B_AUTO];
            end
            if (ur_hit)
                urun_q <= 1'b1;
            else if (wr_en && !wr_data[B_URUN])
                urun_q <= 1'b0;
        end
    end

    // R8: hardware underrun wins over a clearing write
    a_r8_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ur_hit |=> urun_q);
    // R7: the interrupt pulse only accompanies a set flag
    a_r7_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_p |-> urun_q);
    // R6: every toggle write yields a pulse
    a_r6_tog_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_ISO]) |=> (tog_p && iso_q));
    // R5: flush pulse follows a flush write
    a_r5_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_FLUSH]) |=> flush_p);
endmodule

// File: rtl/inep_csr.sv
module inep_csr
    import inep_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             tx_done,
    input  logic             fill_done,
    input  logic             fifo_full,
    input  logic             underrun,
    input  logic             single_buf,
    output logic             pkt_rdy,
    output logic             stall,
    output logic             flush,
    output logic             tog_rst,
    output logic             iso_mode,
    output logic             intr_mode,
    output logic             ur_irq
);
    logic urun_q, auto_q;
    logic set_cpu, set_auto, clr_flush;

    inep_cfg_regs u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (csr_wr),
        .wr_data     (csr_wdata),
        .hw_underrun (underrun),
        .urun_q      (urun_q),
        .stall_q     (stall),
        .iso_q       (iso_mode),
        .intr_q      (intr_mode),
        .auto_q      (auto_q),
        .flush_p     (flush),
        .tog_p       (tog_rst),
        .irq_p       (ur_irq)
    );

    assign set_cpu   = csr_wr && csr_wdata[B_PRDY];
    assign set_auto  = auto_q && single_buf && fill_done;
    assign clr_flush = csr_wr && csr_wdata[B_FLUSH];

    inep_pkt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_cpu   (set_cpu),
        .set_auto  (set_auto),
        .clr_tx    (tx_done),
        .clr_flush (clr_flush),
        .pkt_rdy   (pkt_rdy)
    );

    always_comb begin
        csr_rdata           = '0;
        csr_rdata[B_PRDY]   = pkt_rdy;
        csr_rdata[B_URUN]   = urun_q;
        csr_rdata[B_STALL]  = stall;
        csr_rdata[B_ISO]    = iso_mode;
        csr_rdata[B_INTR]   = intr_mode;
        csr_rdata[B_NEMPTY] = fifo_full;
        csr_rdata[B_FLUSH]  = 1'b0;
        csr_rdata[B_AUTO]   = auto_q;
    end

    // R4: fill completion without the auto gate never arms from idle
    a_r4_no_auto: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_rdy && fill_done && !(auto_q && single_buf) && !csr_wr) |=> !pkt_rdy);
    // R9: status bit tracks the input
    a_r9_nempty: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[B_NEMPTY] == fifo_full);
endmodule

// File: tb/inep_csr_tb_top.sv
module inep_csr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csr_wr = 1'b0;
    logic [7:0] csr_wdata = 8'h00;
    logic [7:0] csr_rdata;
    logic       tx_done = 1'b0, fill_done = 1'b0, fifo_full = 1'b0;
    logic       underrun = 1'b0, single_buf = 1'b0;
    logic       pkt_rdy, stall, flush, tog_rst, iso_mode, intr_mode, ur_irq;
    int         n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    inep_csr dut_i (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .tx_done(tx_done), .fill_done(fill_done),
        .fifo_full(fifo_full), .underrun(underrun), .single_buf(single_buf),
        .pkt_rdy(pkt_rdy), .stall(stall), .flush(flush), .tog_rst(tog_rst),
        .iso_mode(iso_mode), .intr_mode(intr_mode), .ur_irq(ur_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle of stimulus; returns at the negedge after the capturing edge
    task automatic drv(input logic w, input logic [7:0] d, input logic tx,
                       input logic fl, input logic ur);
        @(negedge clk);
        csr_wr = w; csr_wdata = d; tx_done = tx; fill_done = fl; underrun = ur;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = 8'h00; tx_done = 1'b0; fill_done = 1'b0; underrun = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rdata", csr_rdata, 8'h00);
        chk("R1 outputs", {pkt_rdy, stall, flush, tog_rst, iso_mode, intr_mode, ur_irq}, 7'h0);
    endtask

    task automatic t_manual;
        drv(1, 8'h01, 0, 0, 0);
        chk("R2 set", {csr_rdata[0], pkt_rdy}, 2'b11);
        drv(1, 8'h04, 0, 0, 0);
        chk("R2 zero write keeps", csr_rdata[0], 1);
        chk("R10 stall", {stall, csr_rdata[2]}, 2'b11);
        drv(0, 8'h00, 1, 0, 0);
        chk("R3 tx clears", csr_rdata[0], 0);
        drv(1, 8'h10, 0, 0, 0);
        chk("R10 intr", {intr_mode, stall}, 2'b10);
        drv(1, 8'h00, 0, 0, 0);
    endtask

    task automatic t_auto;
        single_buf = 1'b1;
        drv(0, 8'h00, 0, 1, 0);
        chk("R4 auto off", pkt_rdy, 0);
        drv(1, 8'h80, 0, 0, 0);
        chk("R4 auto bit", csr_rdata, 8'h80);
        single_buf = 1'b0;
        drv(0, 8'h00, 0, 1, 0);
        chk("R4 double buffer", pkt_rdy, 0);
        single_buf = 1'b1;
        drv(0, 8'h00, 0, 1, 0);
        chk("R4 auto arms", pkt_rdy, 1);
        drv(0, 8'h00, 1, 1, 0);
        chk("R11 tx beats fill", pkt_rdy, 0);
        drv(1, 8'h00, 0, 0, 0);
    endtask

    task automatic t_flush;
        drv(1, 8'h01, 0, 0, 0);
        drv(1, 8'h40, 0, 0, 0);
        chk("R5 flush pulse", flush, 1);
        chk("R5 flush clears", csr_rdata, 8'h00);
        @(negedge clk);
        chk("R5 flush one cycle", flush, 0);
        drv(1, 8'h41, 0, 0, 0);
        chk("R5 flush beats set", pkt_rdy, 0);
    endtask

    task automatic t_toggle;
        drv(1, 8'h08, 0, 0, 0);
        chk("R6 tog pulse", {tog_rst, iso_mode, csr_rdata[3]}, 3'b111);
        @(negedge clk);
        chk("R6 tog one cycle", tog_rst, 0);
        drv(1, 8'h08, 0, 0, 0);
        chk("R6 tog again", tog_rst, 1);
    endtask

    task automatic t_underrun;
        drv(0, 8'h00, 0, 0, 1);
        chk("R7 flag", csr_rdata[1], 1);
        chk("R7 irq", ur_irq, 1);
        @(negedge clk);
        chk("R7 irq one cycle", ur_irq, 0);
        drv(1, 8'h0A, 0, 0, 0);
        chk("R8 write 1 keeps", csr_rdata[1], 1);
        drv(1, 8'h08, 0, 0, 1);
        chk("R8 hw wins", csr_rdata[1], 1);
        drv(1, 8'h08, 0, 0, 0);
        chk("R8 write 0 clears", csr_rdata[1], 0);
        drv(1, 8'h00, 0, 0, 0);
        drv(0, 8'h00, 0, 0, 1);
        chk("R7 ignored non-iso", {csr_rdata[1], ur_irq}, 2'b00);
    endtask

    task automatic t_status;
        fifo_full = 1'b1;
        @(negedge clk);
        chk("R9 follows input", csr_rdata[5], 1);
        fifo_full = 1'b0;
        drv(1, 8'h20, 0, 0, 0);
        chk("R9 write ignored", csr_rdata, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_manual();
        t_auto();
        t_flush();
        t_toggle();
        t_underrun();
        t_status();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule